// File: doc/BRIEF.md
# Transmit PCM Serial Port with Enable Gating

This block sends an 8-bit PCM sample out one bit at a time through a three-state serial output. An external data clock sets the bit rate. A data-enable input opens the time slot, and a frame-sync input marks the sample period. All three inputs are asynchronous to the block. They are brought into a fast system clock through two-flop synchronizers, and their edges are detected in that clock domain. The system clock must run at least eight times faster than the fastest data clock.

After a frame-sync rising edge, the next enable rising edge produces a one-cycle transmit strobe. The strobe loads the parallel word into a recirculating shift register, with the most significant (sign) bit presented first, and asks the converter for a new sample. While the enable is high, the serial output is driven, and each data-clock rising edge moves it on by one bit. While the enable is low, the output is released and the bit position is held. A slot may therefore be a whole byte (eight data clocks with the enable held high) or single bits spread across a frame. Because the register feeds its last bit back to its first, the same word can be read again. An error pulse marks a strobe that follows the previous enable rising edge with fewer than two data-clock falling edges between them.

Top module: `pcm_tx_port`

## Requirements
- R1: `strobe_o` is a pulse one system clock long. It occurs only for the first enable rising edge after a frame-sync rising edge. An enable rising edge with no frame-sync rising edge since the last strobe produces no strobe.
- R2: A strobe loads `word_i` into the shift register. While the enable stays high, the next slot presents `word_i[7]` on `sdo_o` first, then bits 6 down to 0 in order.
- R3: `sdo_oe_o` follows the synchronized enable. It is 1 while `den_i` is high and 0 while `den_i` is low.
- R4: A data-clock rising edge seen while the enable is low does not move the bit position. The bit presented at the next enabled slot is the one that would have come next.
- R5: The register recirculates. After eight enabled data-clock rising edges, the word repeats from bit 7.
- R6: The enable may drop and rise again in the middle of a word. Shifting then resumes at the bit where it stopped, and no new load takes place.
- R7: `err_o` pulses together with a strobe when fewer than two data-clock falling edges have occurred since the previous enable rising edge. The first strobe after reset never flags an error.
- R8: In reset, `sdo_oe_o`, `strobe_o`, `err_o` and `sdo_o` are all 0, and the shift register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the data clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dclk_i | input | 1 | Asynchronous serial data clock |
| den_i | input | 1 | Asynchronous data enable: slot gate, output enable and strobe trigger |
| fsync_i | input | 1 | Asynchronous frame sync; a rising edge arms the next strobe |
| word_i | input | 8 | Parallel PCM word, sampled on the strobe |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Enable for the external three-state driver |
| strobe_o | output | 1 | One-cycle transmit strobe / conversion request |
| err_o | output | 1 | One-cycle guard violation flag, coincident with the strobe |

## Verification
The hardest case to reach is the guard error. It needs an enable rising edge between frames that sets the guard count back to zero, followed by a frame sync and an armed enable rising edge, with no data-clock falling edge in between. A directed sequence produces exactly that with the data clock held low, and a second sequence inserts two data-clock pulses to show that the flag then stays clear. Random frames that leave the enable high with random gaps between its rising edges produce both outcomes. A bench model tracks the bit position and the number of data-clock falling edges since the last enable rising edge, and predicts every serial bit and every error flag.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
    localparam int NSIG     = 3;
    localparam int IDX_DCLK = 0;
    localparam int IDX_DEN  = 1;
    localparam int IDX_FS   = 2;

    typedef struct packed {
        logic [NSIG-1:0] meta;
        logic [NSIG-1:0] stab;
        logic [NSIG-1:0] hist;
    } sync_st_t;
endpackage

// File: rtl/pcm_tx_sync.sv
module pcm_tx_sync
    import pcm_tx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSIG-1:0] async_i,
    output logic [NSIG-1:0] lvl_o,
    output logic [NSIG-1:0] rise_o,
    output logic [NSIG-1:0] fall_o
);
    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.stab = st_q.meta;
        st_d.hist = st_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NSIG; g++) begin : g_edge
        assign lvl_o[g]  = st_q.stab[g];
        assign rise_o[g] = st_q.stab[g] & ~st_q.hist[g];
        assign fall_o[g] = ~st_q.stab[g] & st_q.hist[g];
    end
endmodule

// File: rtl/pcm_tx_strobe.sv
module pcm_tx_strobe #(
    parameter int GUARD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_rise,
    input  logic den_rise,
    input  logic dclk_fall,
    output logic strobe_o,
    output logic err_o
);
    localparam int CNT_W = $clog2(GUARD + 1);
    localparam logic [CNT_W-1:0] GUARD_C = CNT_W'(GUARD);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] falls;
        logic             strb;
        logic             err;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.strb = 1'b0;
        st_d.err  = 1'b0;
        if (dclk_fall && (st_q.falls < GUARD_C))
            st_d.falls = st_q.falls + 1'b1;
        if (fs_rise)
            st_d.armed = 1'b1;
        if (den_rise) begin
            st_d.falls = '0;
            if (st_q.armed) begin
                st_d.strb  = 1'b1;
                st_d.err   = (st_q.falls < GUARD_C);
                st_d.armed = fs_rise;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.falls <= GUARD_C;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_o = st_q.strb;
    assign err_o    = st_q.err;
endmodule

// File: rtl/pcm_tx_shreg.sv
module pcm_tx_shreg #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] sr_o
);
    typedef struct packed {
        logic [WORD_W-1:0] sr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)
            st_d.sr = word_i;
        else if (shift)
            st_d.sr = {st_q.sr[WORD_W-2:0], st_q.sr[WORD_W-1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sr_o = st_q.sr;
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
    import pcm_tx_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int GUARD  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dclk_i,
    input  logic              den_i,
    input  logic              fsync_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              strobe_o,
    output logic              err_o
);
    logic [NSIG-1:0]   async_vec, lvl, rise, fall;
    logic              den_lvl, shift_en;
    logic [WORD_W-1:0] shreg_q;

    always_comb begin
        async_vec           = '0;
        async_vec[IDX_DCLK] = dclk_i;
        async_vec[IDX_DEN]  = den_i;
        async_vec[IDX_FS]   = fsync_i;
    end

    pcm_tx_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (async_vec),
        .lvl_o   (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    assign den_lvl  = lvl[IDX_DEN];
    assign shift_en = rise[IDX_DCLK] & den_lvl;

    pcm_tx_strobe #(.GUARD(GUARD)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs_rise   (rise[IDX_FS]),
        .den_rise  (rise[IDX_DEN]),
        .dclk_fall (fall[IDX_DCLK]),
        .strobe_o  (strobe_o),
        .err_o     (err_o)
    );

    pcm_tx_shreg #(.WORD_W(WORD_W)) u_shreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (strobe_o),
        .shift  (shift_en),
        .word_i (word_i),
        .sr_o   (shreg_q)
    );

    assign sdo_o    = shreg_q[WORD_W-1];
    assign sdo_oe_o = den_lvl;
endmodule

// File: rtl/pcm_tx_port_chk.sv
module pcm_tx_port_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe_o,
    input logic              err_o,
    input logic              den_lvl,
    input logic              shift_en,
    input logic [WORD_W-1:0] word_i,
    input logic [WORD_W-1:0] shreg_q
);
    assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    assert_load_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> (shreg_q == $past(word_i)));

    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!den_lvl && !strobe_o) |=> $stable(shreg_q));

    assert_recirculate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !strobe_o) |=> (shreg_q[0] == $past(shreg_q[WORD_W-1])));

    assert_err_with_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> strobe_o);
endmodule

bind pcm_tx_port pcm_tx_port_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_o (strobe_o),
    .err_o    (err_o),
    .den_lvl  (den_lvl),
    .shift_en (shift_en),
    .word_i   (word_i),
    .shreg_q  (shreg_q)
);

// File: tb/tb_pcm_tx_port.sv
module tb_pcm_tx_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dclk = 1'b0, den = 1'b0, fsync = 1'b0;
    logic [7:0] word = 8'h00;
    logic       sdo, sdo_oe, strobe, err;

    int n_chk = 0, n_bad = 0;
    int strb_cnt = 0, err_cnt = 0;
    int falls = 2;
    int ptr = 0;
    logic [7:0] mword = 8'h00;
    bit done = 0;

    always #5 clk = ~clk;

    pcm_tx_port dut (
        .clk(clk), .rst_n(rst_n), .dclk_i(dclk), .den_i(den), .fsync_i(fsync),
        .word_i(word), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .strobe_o(strobe), .err_o(err)
    );

    always @(negedge clk) begin
        if (strobe) strb_cnt++;
        if (err)    err_cnt++;
    end

    function automatic logic exp_bit(input logic [7:0] w, input int p);
        return w[7 - (p % 8)];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic dpulse();
        dclk = 1'b1; tick(5);
        dclk = 1'b0; tick(5);
        if (falls < 2) falls++;
    endtask

    task automatic set_den(input logic v);
        if (v && !den) falls = 0;
        den = v;
        tick(4);
    endtask

    // one data-clock slot with the enable at level en; no strobe expected (R1)
    task automatic slot(input logic en);
        int sc;
        sc = strb_cnt;
        set_den(en);
        chk(strb_cnt == sc, "R1", strb_cnt, sc);
        chk(sdo_oe == en, "R3", sdo_oe, en);
        if (en) chk(sdo == exp_bit(mword, ptr), "R2/R5/R6", sdo, exp_bit(mword, ptr));
        dpulse();
        if (en) ptr++;
    endtask

    task automatic start_frame(input logic [7:0] w);
        int sc, ec, xe;
        if (den) set_den(1'b0);
        fsync = 1'b1; tick(4);
        fsync = 1'b0; word = w; tick(2);
        xe = (falls < 2) ? 1 : 0;
        sc = strb_cnt; ec = err_cnt;
        set_den(1'b1); tick(2);
        chk(strb_cnt == sc + 1, "R1", strb_cnt, sc + 1);
        chk(err_cnt == ec + xe, "R7", err_cnt, ec + xe);
        mword = w; ptr = 0;
        chk(sdo == w[7], "R2", sdo, w[7]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int sc;
        void'($urandom(32'd20240611));
        tick(3);
        // R8: reset state
        chk(sdo_oe == 0, "R8", sdo_oe, 0);
        chk(strobe == 0, "R8", strobe, 0);
        chk(err == 0, "R8", err, 0);
        chk(sdo == 0, "R8", sdo, 0);
        rst_n = 1'b1; tick(3);

        // R1: enable rising edge with no frame sync -> no strobe, register still zero
        sc = strb_cnt;
        set_den(1'b1); tick(2);
        chk(strb_cnt == sc, "R1", strb_cnt, sc);
        chk(sdo_oe == 1, "R3", sdo_oe, 1);
        chk(sdo == 0, "R8", sdo, 0);
        set_den(1'b0);
        chk(sdo_oe == 0, "R3", sdo_oe, 0);
        dpulse(); dpulse();

        // byte-interleaved word, read twice (R2, R5); first strobe: no error (R7)
        start_frame(8'hA5);
        for (int i = 0; i < 16; i++) slot(1'b1);

        // R4 / R6: gaps in the middle of a word
        start_frame(8'h3C);
        slot(1'b1); slot(1'b1); slot(1'b1);
        slot(1'b0); slot(1'b0);
        slot(1'b1); slot(1'b0); slot(1'b1); slot(1'b1);
        slot(1'b1); slot(1'b1);

        // R7: guard violated (enable rising edge, then frame strobe, no clock falls)
        set_den(1'b0); set_den(1'b1); set_den(1'b0);
        start_frame(8'h81);
        slot(1'b1); slot(1'b1);
        // R7: guard met with two falls after the last enable rising edge
        set_den(1'b0); set_den(1'b1); dpulse(); dpulse(); set_den(1'b0);
        start_frame(8'h5A);
        slot(1'b1);

        // random frames with random slot patterns
        for (int f = 0; f < 40; f++) begin
            int ns;
            start_frame(8'($urandom));
            ns = 4 + int'($urandom % 14);
            for (int s = 0; s < ns; s++) slot(logic'($urandom % 3 != 0));
            if ($urandom % 2 == 0) begin
                set_den(1'b0); set_den(1'b1);
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule